// File: doc/BRIEF.md
# 8-bit CPU Effective Address Generator

This block turns an addressing-mode code, the two index registers and the operand pointer of a small accumulator CPU into a 16-bit effective address. It fetches operand bytes, and pointer bytes where the mode needs them, through a byte-wide read port. It reports the effective address, the operand pointer advanced past the bytes it consumed, and a flag that asks the sequencer for one extra cycle when indexing crossed a page. Decode, arithmetic and writeback stay outside.

A command enters through a valid/ready pair. `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While busy, the block holds `cmd_ready` low, and a waiting `cmd_valid` is back-pressured and must stay asserted. The read port is a request/acknowledge pair. `rd_req` and `rd_addr` stay steady until the memory returns `rd_ack`, and `rd_data` is taken in that same cycle. The results are registered and stay valid from the cycle `done` pulses until the next command is accepted.

`cmd_pc` is the address of the first operand byte, because the opcode has already been consumed.

Top module: `ea_gen`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `done` and `rd_req` are 0. `cmd_ready` is 0 from the cycle after acceptance until the command completes, and it is never high together with `rd_req` or `done`.
- R2: `rd_req` and `rd_addr` stay unchanged until a cycle with `rd_ack` high, and `rd_data` is sampled in that cycle.
- R3: Multi-byte operands and pointers are read low byte first at the lower address, then the high byte.
- R4: Mode 2 (immediate) performs no read, gives `ea` = `cmd_pc` and `pc_next` = `cmd_pc`+1, and completes with `done` one cycle after acceptance.
- R5: Modes 3 (page zero), 4 (page zero plus X) and 5 (page zero plus Y) read one operand byte. They give `ea` = {8'h00, (operand + index) mod 256} and `pc_next` = `cmd_pc`+1.
- R6: Modes 6 (absolute), 7 (absolute plus X) and 8 (absolute plus Y) read two operand bytes. They give `ea` = operand + index with a full 16-bit carry and `pc_next` = `cmd_pc`+2. In modes 7 and 8, `page_penalty` is 1 exactly when the high byte of `ea` differs from the operand's high byte.
- R7: Mode 9 (X-indexed pointer) reads the operand o, then the pointer low byte at {8'h00, (o+X) mod 256} and the high byte at {8'h00, (o+X+1) mod 256}. The pointer becomes `ea`, and `pc_next` = `cmd_pc`+1.
- R8: Mode 10 (pointer plus Y) reads the pointer at {8'h00, o} and {8'h00, (o+1) mod 256} and gives `ea` = pointer + Y. `page_penalty` is 1 exactly when the high byte of `ea` differs from the pointer's high byte, and `pc_next` = `cmd_pc`+1.
- R9: Mode 11 (absolute pointer) reads a 16-bit operand p, then the target at p and p+1 (16-bit increment), and gives `pc_next` = `cmd_pc`+2.
- R10: Mode 12 (relative) reads one offset byte and gives `pc_next` = `cmd_pc`+1 and `ea` = `pc_next` + the sign-extended offset.
- R11: Modes 0 (implied), 1 (accumulator) and the unused codes 13 to 15 perform no read. They give `ea` = 0 and `pc_next` = `cmd_pc`, and `done` pulses one cycle after acceptance.
- R12: `done` is high for exactly one cycle per command, and `page_penalty` is 0 for every mode other than 7, 8 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_mode | input | 4 | Addressing-mode code |
| cmd_x | input | 8 | X index value |
| cmd_y | input | 8 | Y index value |
| cmd_pc | input | 16 | Address of the first operand byte |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_ack | input | 1 | Read data present this cycle |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| pc_next | output | 16 | Operand pointer after the consumed bytes |
| page_penalty | output | 1 | Indexing crossed a page; one extra cycle |

## Verification
The hardest situations to reach are the wrap and carry edges that only appear for particular memory contents. One is the pointer high-byte fetch at page-zero location FF, which must wrap to 00. The others are an index sum that carries out of the pointer's low byte, and a negative relative offset that lands in the previous page. The bench memory is a computed function of address and a per-command salt. Directed cases solve for the salt that puts the wanted operand byte at `cmd_pc`, and random commands with random acknowledge delays cover the rest against a bench model.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_IMP  = 4'd0,
    M_ACC  = 4'd1,
    M_IMM  = 4'd2,
    M_ZP   = 4'd3,
    M_ZPX  = 4'd4,
    M_ZPY  = 4'd5,
    M_ABS  = 4'd6,
    M_ABSX = 4'd7,
    M_ABSY = 4'd8,
    M_INDX = 4'd9,
    M_INDY = 4'd10,
    M_IND  = 4'd11,
    M_REL  = 4'd12
  } ea_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPLO,
    S_OPHI,
    S_PLO,
    S_PHI,
    S_FIN
  } ea_state_e;

  function automatic logic picks_x(ea_mode_e m);
    return (m == M_ZPX) || (m == M_ABSX) || (m == M_INDX);
  endfunction

  function automatic logic zp_pointer(ea_mode_e m);
    return (m == M_INDX) || (m == M_INDY);
  endfunction
endpackage

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] off,
  output logic [AW-1:0] sum,
  output logic          page_cross
);
  assign sum        = base + off;
  assign page_cross = (sum[AW-1:DW] != base[AW-1:DW]);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [MODE_W-1:0] cmd_mode,
  input  logic [DW-1:0]     cmd_x,
  input  logic [DW-1:0]     cmd_y,
  input  logic [AW-1:0]     cmd_pc,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [DW-1:0]     rd_data,
  output logic              done,
  output logic [AW-1:0]     ea,
  output logic [AW-1:0]     pc_next,
  output logic              page_penalty
);
  localparam int HW = AW - DW;

  ea_state_e       state;
  ea_mode_e        mode_q;
  ea_mode_e        cmd_m;
  logic [DW-1:0]   x_q, y_q, lo_q, idx;
  logic [AW-1:0]   pc_q, ptr_q, ea_q;
  logic            pen_q;

  logic [AW-1:0]   a_base, a_off, a_sum;
  logic            a_cross;
  logic [AW-1:0]   inc_sum, ptr_hi_addr;
  logic            inc_cross;
  logic [DW-1:0]   zp_sum;
  logic            accept;

  assign cmd_m  = ea_mode_e'(cmd_mode);
  assign accept = cmd_valid && cmd_ready;
  assign idx    = picks_x(mode_q) ? x_q : y_q;
  assign zp_sum = rd_data + idx;

  // Index / relative adder
  always_comb begin
    if (state == S_OPLO) begin
      a_base = pc_q + 1'b1;
      a_off  = {{HW{rd_data[DW-1]}}, rd_data};
    end else begin
      a_base = {rd_data, lo_q};
      a_off  = {{HW{1'b0}}, idx};
    end
  end

  ea_adder #(.AW(AW), .DW(DW)) u_idx_add (
    .base(a_base), .off(a_off), .sum(a_sum), .page_cross(a_cross)
  );

  // Pointer high-byte address
  ea_adder #(.AW(AW), .DW(DW)) u_ptr_inc (
    .base(ptr_q), .off({{(AW-1){1'b0}}, 1'b1}), .sum(inc_sum), .page_cross(inc_cross)
  );

  assign ptr_hi_addr = (zp_pointer(mode_q) && inc_cross) ?
                       {ptr_q[AW-1:DW], inc_sum[DW-1:0]} : inc_sum;

  assign cmd_ready = (state == S_IDLE);
  assign rd_req    = (state == S_OPLO) || (state == S_OPHI) ||
                     (state == S_PLO)  || (state == S_PHI);
  always_comb begin
    case (state)
      S_OPLO, S_OPHI: rd_addr = pc_q;
      S_PHI:          rd_addr = ptr_hi_addr;
      default:        rd_addr = ptr_q;
    endcase
  end

  assign done         = (state == S_FIN);
  assign ea           = ea_q;
  assign pc_next      = pc_q;
  assign page_penalty = pen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= M_IMP;
      x_q    <= '0;
      y_q    <= '0;
      lo_q   <= '0;
      pc_q   <= '0;
      ptr_q  <= '0;
      ea_q   <= '0;
      pen_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          mode_q <= cmd_m;
          x_q    <= cmd_x;
          y_q    <= cmd_y;
          pc_q   <= cmd_pc;
          pen_q  <= 1'b0;
          ea_q   <= '0;
          case (cmd_m)
            M_IMM: begin
              ea_q  <= cmd_pc;
              pc_q  <= cmd_pc + 1'b1;
              state <= S_FIN;
            end
            M_ZP, M_ZPX, M_ZPY, M_ABS, M_ABSX, M_ABSY,
            M_INDX, M_INDY, M_IND, M_REL: state <= S_OPLO;
            default: state <= S_FIN;
          endcase
        end
        S_OPLO: if (rd_ack) begin
          lo_q <= rd_data;
          pc_q <= pc_q + 1'b1;
          case (mode_q)
            M_ZP: begin
              ea_q  <= {{HW{1'b0}}, rd_data};
              state <= S_FIN;
            end
            M_ZPX, M_ZPY: begin
              ea_q  <= {{HW{1'b0}}, zp_sum};
              state <= S_FIN;
            end
            M_REL: begin
              ea_q  <= a_sum;
              state <= S_FIN;
            end
            M_INDX: begin
              ptr_q <= {{HW{1'b0}}, zp_sum};
              state <= S_PLO;
            end
            M_INDY: begin
              ptr_q <= {{HW{1'b0}}, rd_data};
              state <= S_PLO;
            end
            default: state <= S_OPHI;
          endcase
        end
        S_OPHI: if (rd_ack) begin
          pc_q <= pc_q + 1'b1;
          case (mode_q)
            M_ABS: begin
              ea_q  <= {rd_data, lo_q};
              state <= S_FIN;
            end
            M_ABSX, M_ABSY: begin
              ea_q  <= a_sum;
              pen_q <= a_cross;
              state <= S_FIN;
            end
            default: begin
              ptr_q <= {rd_data, lo_q};
              state <= S_PLO;
            end
          endcase
        end
        S_PLO: if (rd_ack) begin
          lo_q  <= rd_data;
          state <= S_PHI;
        end
        S_PHI: if (rd_ack) begin
          if (mode_q == M_INDY) begin
            ea_q  <= a_sum;
            pen_q <= a_cross;
          end else begin
            ea_q <= {rd_data, lo_q};
          end
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!rd_req && !done));

  // R5
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY))
      |-> (ea[AW-1:DW] == '0));

  // R12
  pen_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && page_penalty) |-> (mode_q == M_ABSX || mode_q == M_ABSY || mode_q == M_INDY));

  // R11
  imp_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cmd_mode <= 4'd1 || cmd_mode >= 4'd13)) |=> (done && !rd_req && ea == '0));

  // R4
  imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_mode == 4'd2) |=> (done && ea == $past(cmd_pc)));
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_mode = '0;
  logic [7:0]  cmd_x = '0, cmd_y = '0;
  logic [15:0] cmd_pc = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = '0;
  logic        done;
  logic [15:0] ea, pc_next;
  logic        page_penalty;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  salt = '0;
  int          nrd = 0;
  logic [15:0] alog [4];
  int          wait_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_pc(cmd_pc),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .ea(ea), .pc_next(pc_next), .page_penalty(page_penalty)
  );

  function automatic logic [7:0] mem(logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ salt;
  endfunction

  function automatic void salt_for(logic [15:0] a, logic [7:0] want);
    salt = want ^ a[7:0] ^ {a[14:8], a[15]};
  endfunction

  function automatic string tag_of(logic [3:0] m);
    case (m)
      4'd2: return "R4";
      4'd3, 4'd4, 4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      4'd11: return "R9";
      4'd12: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Bench model of the addressing rules
  task automatic model(input logic [3:0] m, input logic [7:0] x, input logic [7:0] y,
                       input logic [15:0] pc, output logic [15:0] e, output logic [15:0] pn,
                       output logic pen, output int n, output logic [15:0] ad [4]);
    logic [7:0] o, lo, hi, p8;
    logic [15:0] b, p;
    e = '0; pn = pc; pen = 1'b0; n = 0;
    for (int i = 0; i < 4; i++) ad[i] = '0;
    o = mem(pc);
    case (m)
      4'd2: begin e = pc; pn = pc + 16'd1; end
      4'd3, 4'd4, 4'd5: begin
        p8 = o + ((m == 4'd4) ? x : (m == 4'd5) ? y : 8'd0);
        e = {8'h00, p8}; pn = pc + 16'd1; n = 1; ad[0] = pc;
      end
      4'd6, 4'd7, 4'd8: begin
        hi = mem(pc + 16'd1); b = {hi, o};
        e = b + {8'h00, (m == 4'd7) ? x : (m == 4'd8) ? y : 8'd0};
        pen = (m != 4'd6) && (e[15:8] != hi);
        pn = pc + 16'd2; n = 2; ad[0] = pc; ad[1] = pc + 16'd1;
      end
      4'd9: begin
        p8 = o + x; lo = mem({8'h00, p8}); hi = mem({8'h00, p8 + 8'd1});
        e = {hi, lo}; pn = pc + 16'd1; n = 3;
        ad[0] = pc; ad[1] = {8'h00, p8}; ad[2] = {8'h00, p8 + 8'd1};
      end
      4'd10: begin
        lo = mem({8'h00, o}); hi = mem({8'h00, o + 8'd1});
        e = {hi, lo} + {8'h00, y}; pen = (e[15:8] != hi);
        pn = pc + 16'd1; n = 3;
        ad[0] = pc; ad[1] = {8'h00, o}; ad[2] = {8'h00, o + 8'd1};
      end
      4'd11: begin
        p = {mem(pc + 16'd1), o};
        e = {mem(p + 16'd1), mem(p)}; pn = pc + 16'd2; n = 4;
        ad[0] = pc; ad[1] = pc + 16'd1; ad[2] = p; ad[3] = p + 16'd1;
      end
      4'd12: begin
        pn = pc + 16'd1; e = pn + {{8{o[7]}}, o}; n = 1; ad[0] = pc;
      end
      default: ;
    endcase
  endtask

  // Memory responder with random acknowledge delay
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
        rd_data = 8'h00;
      end else if (rd_req) begin
        if (wait_cnt == 0) begin
          rd_ack = 1'b1;
          rd_data = mem(rd_addr);
          if (nrd < 4) alog[nrd] = rd_addr;
          nrd++;
          wait_cnt = int'($urandom % 3);
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic run_op(logic [3:0] m, logic [7:0] x, logic [7:0] y, logic [15:0] pc);
    logic [15:0] e, pn;
    logic pen;
    int n, cyc;
    logic [15:0] ad [4];
    string t;
    t = tag_of(m);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    model(m, x, y, pc, e, pn, pen, n, ad);
    nrd = 0;
    cmd_valid = 1'b1; cmd_mode = m; cmd_x = x; cmd_y = y; cmd_pc = pc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (n > 0) chk(!cmd_ready, "R1", "ready while busy", 32'(cmd_ready), 32'd0);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, t, "done seen", 32'(done), 32'd1);
    chk(ea == e, t, "ea", 32'(ea), 32'(e));
    chk(pc_next == pn, t, "pc_next", 32'(pc_next), 32'(pn));
    chk(page_penalty == pen, (m == 4'd7 || m == 4'd8 || m == 4'd10) ? t : "R12",
        "page_penalty", 32'(page_penalty), 32'(pen));
    chk(nrd == n, t, "read count", 32'(nrd), 32'(n));
    for (int i = 0; i < 4; i++)
      if (i < n && i < nrd)
        chk(alog[i] == ad[i], (i == 0) ? t : "R3", "read address order",
            32'(alog[i]), 32'(ad[i]));
    @(negedge clk);
    chk(!done, "R12", "done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "reset ready", 32'(cmd_ready), 32'd1);
    chk(done == 1'b0, "R1", "reset done", 32'(done), 32'd0);
    chk(rd_req == 1'b0, "R1", "reset rd_req", 32'(rd_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", 32'(cmd_ready), 32'd1);

    // Directed corners
    salt = 8'h5a; run_op(4'd2, 8'h00, 8'h00, 16'hFFFF);             // R4 pc wraps
    salt_for(16'h1234, 8'hF0); run_op(4'd4, 8'h20, 8'h00, 16'h1234); // R5 wrap to page zero
    salt_for(16'h0300, 8'hFF); run_op(4'd5, 8'h00, 8'h01, 16'h0300); // R5
    salt_for(16'h2000, 8'hF0); run_op(4'd7, 8'h20, 8'h00, 16'h2000); // R6 carry
    salt_for(16'h2000, 8'h10); run_op(4'd8, 8'h00, 8'h20, 16'h2000); // R6 no carry
    salt_for(16'h4000, 8'hFE); run_op(4'd9, 8'h01, 8'h00, 16'h4000); // R7 pointer at FF
    salt_for(16'h4100, 8'hFF); run_op(4'd10, 8'h00, 8'hFF, 16'h4100); // R8 pointer at FF
    salt_for(16'h5000, 8'hFF); run_op(4'd11, 8'h00, 8'h00, 16'h5000); // R9
    salt_for(16'h6000, 8'h80); run_op(4'd12, 8'h00, 8'h00, 16'h6000); // R10 backward page
    salt_for(16'h60F0, 8'h7F); run_op(4'd12, 8'h00, 8'h00, 16'h60F0); // R10 forward page
    salt = 8'h33; run_op(4'd0, 8'h11, 8'h22, 16'h7777);             // R11
    salt = 8'h33; run_op(4'd1, 8'h11, 8'h22, 16'h7777);             // R11
    salt = 8'h33; run_op(4'd14, 8'h11, 8'h22, 16'h7777);            // R11 unused code

    // Random mix
    for (int k = 0; k < 600; k++) begin
      salt = 8'($urandom);
      run_op(4'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule